// File: doc/BRIEF.md
# Filtered Quadrature Input Decoder

This block is the front end of one motion axis. It takes the two raw encoder lines, A and B, and turns them into a one-cycle count strobe and a direction bit for a separate position counter. Both lines pass through a synchroniser. In the quadrature modes they then pass through a digital noise filter. The filter samples on a tick from a reloadable prescaler, so software can match the filter bandwidth to the encoder speed. For correct counting the tick rate should be at least eight times the A or B frequency.

Four resolutions are available: plain clock-and-direction, where A is the count clock and B gives direction, and quadrature x1, x2 and x4. A sticky error flag reports an input disturbance that got through the filter as a simultaneous change of both lines. Two enable controls can gate counting: a static enable bit and an optional enable-gate pin. An index input, taken from one of two pins with selectable polarity, can be aligned to the decoded count strobes. A downstream counter can then reset or load on it.

Top module: `qd_front`

## Requirements
- R1: After `presc_load` with value N (0 to 255), `fclk_tick` is a one-cycle pulse that repeats every N+1 clock cycles. After reset N is 0, so a tick occurs every cycle.
- R2: In the quadrature modes, a level on A or B is accepted only after two consecutive filter ticks have sampled it. A pulse shorter than one tick period produces no count.
- R3: The `mode` input takes 2'b01 for x1. In x1, one count occurs per accepted rising edge of A. The count is up when B is low at that edge and down when B is high.
- R4: The `mode` input takes 2'b10 for x2. In x2, one count occurs per accepted edge of A, rising or falling. The direction is up when A differs from B after the edge.
- R5: The `mode` input takes 2'b11 for x4. In x4, one count occurs per accepted edge of A or B. The forward sequence (A,B) = 00, 10, 11, 01 counts up, and the reverse sequence counts down, so a full cycle moves the count by 4.
- R6: The `mode` input takes 2'b00 for plain mode. In plain mode the filter is bypassed. Each rising edge of synchronised A counts once, up when B is high and down when B is low.
- R7: In a quadrature mode, `err_flag` sets when A and B are both accepted as changed on the same filter tick, and that event produces no count. The flag stays set until `err_clr` is pulsed.
- R8: In plain mode, `err_flag` never becomes set.
- R9: With `ab_enable` low, no count strobe is produced. With `gate_sel` high, counts occur only while `gate_pin` is high.
- R10: With `idx_en` high in a quadrature mode, `idx_hit` pulses only together with a count strobe while the selected index pin is at its active level. `idx_sel` 0 picks `idx_pin0` and 1 picks `idx_pin1`. `idx_pol` 1 means active high and 0 means active low.
- R11: With `idx_en` low, `idx_hit` follows the synchronised active level of the selected index pin.
- R12: Reset clears `cnt_en`, `err_flag` and `idx_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter/system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_a | input | 1 | Raw encoder line A |
| pin_b | input | 1 | Raw encoder line B |
| mode | input | 2 | 00 plain, 01 x1, 10 x2, 11 x4 |
| ab_enable | input | 1 | Static count enable |
| gate_sel | input | 1 | Use gate_pin as count enable gate |
| gate_pin | input | 1 | Raw enable-gate pin |
| presc_n | input | PSC_W | Prescaler reload value N |
| presc_load | input | 1 | Load presc_n into the prescaler |
| err_clr | input | 1 | Clear the error flag |
| idx_en | input | 1 | Align index to count strobes |
| idx_pol | input | 1 | Index active level (1 = high) |
| idx_sel | input | 1 | Index pin select |
| idx_pin0 | input | 1 | Raw index candidate 0 |
| idx_pin1 | input | 1 | Raw index candidate 1 |
| fclk_tick | output | 1 | Filter sample tick |
| cnt_en | output | 1 | One-cycle count strobe |
| cnt_up | output | 1 | Direction of the last strobe |
| err_flag | output | 1 | Sticky input error |
| idx_hit | output | 1 | Index indication |

## Verification
The hardest condition to reach from the ports is a disturbance that gets through the filter, because single glitches are deliberately removed. The bench produces it by switching A and B in the same cycle and holding both long enough that the filter accepts them on one tick. It then checks the flag's persistence and both ways of clearing it. Rejection is shown with a glitch shorter than one tick period at a slow prescaler setting, and acceptance with the same level held for a longer time.

// File: rtl/qd_pkg.sv
package qd_pkg;
   typedef enum logic [1:0] {
      QD_PLAIN = 2'b00,
      QD_X1    = 2'b01,
      QD_X2    = 2'b10,
      QD_X4    = 2'b11
   } qd_mode_e;

   function automatic logic qd_is_quad(qd_mode_e m);
      return m != QD_PLAIN;
   endfunction
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/qd_psc.sv
module qd_psc #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] n_in,
   output logic         tick
);
   generate
      if (W < 1) begin : g_bad_w
         $error("qd_psc: W must be positive");
      end
   endgenerate

   logic [W-1:0] reload_q;
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         cnt_q    <= '0;
         tick     <= 1'b0;
      end else if (load) begin
         reload_q <= n_in;
         cnt_q    <= n_in;
         tick     <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q    <= reload_q;
         tick     <= 1'b1;
      end else begin
         cnt_q    <= cnt_q - 1'b1;
         tick     <= 1'b0;
      end
   end
endmodule

// File: rtl/qd_filt.sv
module qd_filt #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic d,
   output logic q
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("qd_filt: DEPTH must be at least 2");
      end
   endgenerate

   // Earlier samples plus the current input form the vote window.
   logic [DEPTH-2:0] hist_q;
   logic [DEPTH-1:0] win;
   logic             agree;

   assign win   = {hist_q, d};
   assign agree = (&win) | ~(|win);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
         q      <= 1'b0;
      end else if (tick) begin
         hist_q <= win[DEPTH-2:0];
         if (agree && (win[0] != q)) q <= win[0];
      end
   end
endmodule

// File: rtl/qd_decode.sv
module qd_decode
   import qd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  qd_mode_e mode,
   input  logic     qa,
   input  logic     qb,
   input  logic     en,
   input  logic     err_clr,
   input  logic     idx_en,
   input  logic     idx_act,
   output logic     cnt_en,
   output logic     cnt_up,
   output logic     err_flag,
   output logic     idx_hit
);
   logic pa_q, pb_q;
   logic ea, eb, pulse, up, dbl;

   always_comb begin
      ea    = qa ^ pa_q;
      eb    = qb ^ pb_q;
      pulse = 1'b0;
      up    = 1'b0;
      case (mode)
         QD_PLAIN: begin
            pulse = qa & ~pa_q;
            up    = qb;
         end
         QD_X1: begin
            pulse = ea & qa & ~eb;
            up    = ~qb;
         end
         QD_X2: begin
            pulse = ea & ~eb;
            up    = qa ^ qb;
         end
         default: begin
            pulse = ea ^ eb;
            up    = ea ? (qa ^ qb) : ~(qa ^ qb);
         end
      endcase
      dbl = qd_is_quad(mode) & ea & eb;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pa_q     <= 1'b0;
         pb_q     <= 1'b0;
         cnt_en   <= 1'b0;
         cnt_up   <= 1'b0;
         err_flag <= 1'b0;
         idx_hit  <= 1'b0;
      end else begin
         pa_q   <= qa;
         pb_q   <= qb;
         cnt_en <= pulse & en;
         if (pulse) cnt_up <= up;
         if (err_clr)  err_flag <= 1'b0;
         else if (dbl) err_flag <= 1'b1;
         if (idx_en && qd_is_quad(mode)) idx_hit <= idx_act & pulse & en;
         else                            idx_hit <= idx_act;
      end
   end
endmodule

// File: rtl/qd_front.sv
module qd_front
   import qd_pkg::*;
#(
   parameter int PSC_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_DEPTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_a,
   input  logic             pin_b,
   input  logic [1:0]       mode,
   input  logic             ab_enable,
   input  logic             gate_sel,
   input  logic             gate_pin,
   input  logic [PSC_W-1:0] presc_n,
   input  logic             presc_load,
   input  logic             err_clr,
   input  logic             idx_en,
   input  logic             idx_pol,
   input  logic             idx_sel,
   input  logic             idx_pin0,
   input  logic             idx_pin1,
   output logic             fclk_tick,
   output logic             cnt_en,
   output logic             cnt_up,
   output logic             err_flag,
   output logic             idx_hit
);
   localparam int NCH = 2;

   qd_mode_e       mode_e;
   logic [NCH-1:0] raw_ab, sync_ab, filt_ab, sel_ab;
   logic           gate_s, idx_s, idx_raw, idx_act, en;

   assign mode_e = qd_mode_e'(mode);
   assign raw_ab = {pin_b, pin_a};

   qd_psc #(.W(PSC_W)) psc_i (
      .clk(clk), .rst_n(rst_n), .load(presc_load), .n_in(presc_n), .tick(fclk_tick)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      qd_sync #(.STAGES(SYNC_STAGES)) sync_i (
         .clk(clk), .rst_n(rst_n), .d(raw_ab[i]), .q(sync_ab[i])
      );
      qd_filt #(.DEPTH(FILT_DEPTH)) filt_i (
         .clk(clk), .rst_n(rst_n), .tick(fclk_tick), .d(sync_ab[i]), .q(filt_ab[i])
      );
      assign sel_ab[i] = qd_is_quad(mode_e) ? filt_ab[i] : sync_ab[i];
   end

   assign idx_raw = idx_sel ? idx_pin1 : idx_pin0;

   qd_sync #(.STAGES(SYNC_STAGES)) gate_sync_i (
      .clk(clk), .rst_n(rst_n), .d(gate_pin), .q(gate_s)
   );
   qd_sync #(.STAGES(SYNC_STAGES)) idx_sync_i (
      .clk(clk), .rst_n(rst_n), .d(idx_raw), .q(idx_s)
   );

   assign idx_act = (idx_s == idx_pol);
   assign en      = ab_enable & (~gate_sel | gate_s);

   qd_decode dec_i (
      .clk(clk), .rst_n(rst_n), .mode(mode_e),
      .qa(sel_ab[0]), .qb(sel_ab[1]), .en(en), .err_clr(err_clr),
      .idx_en(idx_en), .idx_act(idx_act),
      .cnt_en(cnt_en), .cnt_up(cnt_up), .err_flag(err_flag), .idx_hit(idx_hit)
   );
endmodule

// File: rtl/qd_front_chk.sv
module qd_front_chk #(
   parameter int PSC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pin_a,
   input logic             pin_b,
   input logic [1:0]       mode,
   input logic             ab_enable,
   input logic             gate_sel,
   input logic             gate_pin,
   input logic [PSC_W-1:0] presc_n,
   input logic             presc_load,
   input logic             err_clr,
   input logic             idx_en,
   input logic             idx_pol,
   input logic             idx_sel,
   input logic             idx_pin0,
   input logic             idx_pin1,
   input logic             fclk_tick,
   input logic             cnt_en,
   input logic             cnt_up,
   input logic             err_flag,
   input logic             idx_hit
);
   a_r1_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      presc_load |=> !fclk_tick);

   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag);

   a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> !err_flag);

   a_r8_plain_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !err_flag) |=> !err_flag);

   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ab_enable |=> !cnt_en);

   a_r10_idx_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_en && $stable(idx_en) && mode != 2'b00 && $stable(mode) && idx_hit) |-> cnt_en);

   a_r3_x1_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01 && $stable(mode) && cnt_en) |=> !cnt_en);
endmodule

bind qd_front qd_front_chk #(.PSC_W(PSC_W)) chk_i (.*);

// File: tb/qd_front_tb_top.sv
module qd_front_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_a = 0, pin_b = 0;
   logic [1:0] mode = 2'b11;
   logic       ab_enable = 1, gate_sel = 0, gate_pin = 1;
   logic [7:0] presc_n = 8'd0;
   logic       presc_load = 0, err_clr = 0;
   logic       idx_en = 0, idx_pol = 1, idx_sel = 0, idx_pin0 = 0, idx_pin1 = 0;
   logic       fclk_tick, cnt_en, cnt_up, err_flag, idx_hit;

   int n_chk = 0, n_bad = 0;
   int acc = 0, idx_cnt = 0, st = 0;

   always #5 clk = ~clk;

   qd_front dut_i (.*);

   // Strobe monitor, sampled 2 ns after the rising edge.
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (cnt_en) acc += cnt_up ? 1 : -1;
         if (idx_hit && idx_en) idx_cnt++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_ab(input logic a, input logic b);
      @(negedge clk);
      pin_a = a;
      pin_b = b;
   endtask

   task automatic step(input int dir, input int hold);
      st = (st + dir) & 3;
      case (st)
         0:       set_ab(0, 0);
         1:       set_ab(1, 0);
         2:       set_ab(1, 1);
         default: set_ab(0, 1);
      endcase
      idle(hold);
   endtask

   task automatic load_n(input logic [7:0] n);
      @(negedge clk);
      presc_n = n;
      presc_load = 1;
      @(negedge clk);
      presc_load = 0;
   endtask

   task automatic test_reset;
      rst_n = 0;
      idle(3);
      chk("R12 cnt_en in reset", int'(cnt_en), 0);
      chk("R12 err_flag in reset", int'(err_flag), 0);
      chk("R12 idx_hit in reset", int'(idx_hit), 0);
      rst_n = 1;
      idle(2);
      chk("R1 tick every cycle after reset", int'(fclk_tick), 1);
   endtask

   task automatic measure(input logic [7:0] n, input string req);
      int per;
      load_n(n);
      do @(negedge clk); while (!fclk_tick);
      per = 0;
      do begin @(negedge clk); per++; end while (!fclk_tick);
      chk(req, per, int'(n) + 1);
   endtask

   task automatic test_psc;
      measure(8'd4, "R1 period N=4");
      measure(8'd0, "R1 period N=0");
      measure(8'd255, "R1 period N=255");
   endtask

   task automatic run_quad(input logic [1:0] m, input int fwd, input int rev, input string req);
      int base;
      load_n(8'd1);
      mode = m;
      idle(40);
      base = acc;
      for (int i = 0; i < 8; i++) step(1, 20);
      chk({req, " forward"}, acc - base, fwd);
      base = acc;
      for (int i = 0; i < 8; i++) step(-1, 20);
      chk({req, " reverse"}, acc - base, rev);
   endtask

   task automatic test_filter;
      int base;
      load_n(8'd7);
      mode = 2'b11;
      idle(40);
      base = acc;
      set_ab(1, 0);
      idle(3);
      set_ab(0, 0);
      idle(60);
      chk("R2 short glitch ignored", acc - base, 0);
      step(1, 60);
      chk("R2 held level accepted", acc - base, 1);
      step(-1, 60);
   endtask

   task automatic test_err;
      int base;
      load_n(8'd1);
      mode = 2'b11;
      idle(20);
      base = acc;
      set_ab(1, 1);
      idle(30);
      chk("R7 err set on double change", int'(err_flag), 1);
      idle(30);
      chk("R7 err sticky", int'(err_flag), 1);
      chk("R7 no count on double change", acc - base, 0);
      @(negedge clk); err_clr = 1;
      @(negedge clk); err_clr = 0;
      idle(2);
      chk("R7 err cleared", int'(err_flag), 0);
      set_ab(0, 0);
      idle(30);
      chk("R7 err set again", int'(err_flag), 1);
      rst_n = 0;
      idle(2);
      rst_n = 1;
      idle(10);
      chk("R12 reset clears err", int'(err_flag), 0);
      st = 0;
   endtask

   task automatic test_plain;
      int base;
      load_n(8'd255);
      mode = 2'b00;
      idle(10);
      set_ab(0, 1);
      idle(5);
      base = acc;
      for (int i = 0; i < 5; i++) begin
         set_ab(1, 1); idle(1);
         set_ab(0, 1); idle(1);
      end
      idle(6);
      chk("R6 plain up count, filter bypassed", acc - base, 5);
      set_ab(0, 0);
      idle(5);
      base = acc;
      for (int i = 0; i < 3; i++) begin
         set_ab(1, 0); idle(1);
         set_ab(0, 0); idle(1);
      end
      idle(6);
      chk("R6 plain down count", acc - base, -3);
      set_ab(1, 1);
      idle(10);
      set_ab(0, 0);
      idle(10);
      chk("R8 no err in plain mode", int'(err_flag), 0);
      load_n(8'd1);
      idle(40);
      mode = 2'b11;
      idle(20);
      st = 0;
   endtask

   task automatic test_enable;
      int base;
      load_n(8'd1);
      mode = 2'b11;
      idle(20);
      ab_enable = 0;
      base = acc;
      for (int i = 0; i < 4; i++) step(1, 20);
      chk("R9 ab_enable low blocks counts", acc - base, 0);
      ab_enable = 1;
      gate_sel = 1;
      gate_pin = 0;
      idle(10);
      base = acc;
      for (int i = 0; i < 4; i++) step(1, 20);
      chk("R9 gate low blocks counts", acc - base, 0);
      gate_pin = 1;
      idle(10);
      base = acc;
      for (int i = 0; i < 4; i++) step(1, 20);
      chk("R9 gate high allows counts", acc - base, 4);
      gate_sel = 0;
   endtask

   task automatic test_index;
      int base;
      mode = 2'b11;
      idx_en = 1;
      idx_pol = 1;
      idx_sel = 0;
      idx_pin0 = 1;
      idle(10);
      base = idx_cnt;
      for (int i = 0; i < 4; i++) step(1, 20);
      chk("R10 index aligned to strobes pin0", idx_cnt - base, 4);
      idx_pol = 0;
      idle(10);
      base = idx_cnt;
      for (int i = 0; i < 4; i++) step(1, 20);
      chk("R10 inactive polarity gives no hit", idx_cnt - base, 0);
      idx_pol = 1;
      idx_sel = 1;
      idx_pin1 = 1;
      idx_pin0 = 0;
      idle(10);
      base = idx_cnt;
      for (int i = 0; i < 4; i++) step(1, 20);
      chk("R10 index from pin1", idx_cnt - base, 4);
      idx_en = 0;
      idle(8);
      chk("R11 level index active", int'(idx_hit), 1);
      idx_pin1 = 0;
      idle(8);
      chk("R11 level index inactive", int'(idx_hit), 0);
      idx_sel = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      test_reset();
      test_psc();
      run_quad(2'b11, 8, -8, "R5 x4");
      run_quad(2'b10, 4, -4, "R4 x2");
      run_quad(2'b01, 2, -2, "R3 x1");
      test_filter();
      test_err();
      test_plain();
      test_enable();
      test_index();
      idle(5);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule